// File: doc/BRIEF.md
# E1 Spare-Bit Source Selector with Biframe Lock

The block supplies the five spare (national) bits carried in each transmitted E1 frame that holds no frame alignment word. Each bit position is a 4 kbit/s link toward the far end. The word comes from one of three places. A configuration word is the default and has the highest priority. A facility data-link stream comes second. The system-side time-slot-0 stream comes third. Selection is a fixed priority over three enable pins. When no enable is set, the configuration word is used.

When the system stream is the source, each accepted system beat describes one received frame: its time-slot-0 bit 2 and its five spare bits. In the default mode, frames with bit 2 = 1 carry spare data and must alternate with frames that have bit 2 = 0. A tracker watches this alternation. It declares lock after two correct alternations in a row and loss on the first violation. While the block is unlocked, spare words taken from the system stream are forced to all ones. In the alternate mode, which needs two configuration pins set together, the block counts system beats from reset and takes words only from beats of one chosen parity. In this mode it ignores bit 2 and never forces the word.

All data interfaces are valid/ready, and a transfer happens on a clock edge where both are high. The output is a single register. It holds its word while `out_valid` is high and `out_ready` is low. During that time `fdl_ready` is low, and `sys_ready` is low when the system stream is selected. A source that is not selected is still accepted freely and produces no word.

Top module: `sa_source_sel`

## Requirements
- R1: When `cfg_reg_en`=1, or when no enable is set, the output continuously presents `cfg_sa`, and `fdl_ready` stays 0.
- R2: When `cfg_reg_en`=0 and `cfg_fdl_en`=1, whatever `cfg_sys_en` is, each accepted facility word appears once, in order, on `out_sa`. System beats are accepted (`sys_ready`=1) and produce no output word.
- R3: When `cfg_reg_en`=0, `cfg_fdl_en`=0 and `cfg_sys_en`=1, output words come only from accepted system beats.
- R4: While `out_valid`=1 and `out_ready`=0, `out_sa` and `out_valid` hold, and `fdl_ready` is 0.
- R5: In the default system mode, an accepted beat with `sys_bit2`=1 yields exactly one word, and a beat with `sys_bit2`=0 yields none.
- R6: A beat is a correct alternation when its `sys_bit2` differs from that of the previous accepted beat. The first beat after reset has no predecessor. After two correct alternations in a row while unlocked, `stat_locked` becomes 1 and `stat_regained` is set, one cycle after the beat. `stat_locked` changes only on accepted beats.
- R7: While locked, a beat whose `sys_bit2` equals the previous one clears `stat_locked` and sets `stat_lost`, one cycle after the beat.
- R8: In the default system mode, a word from a beat after which the block is unlocked is 5'h1F. A word from a beat after which the block is locked carries `sys_sa` unchanged.
- R9: Alternate mode is active only when `cfg_alt_mode`=1 and `cfg_alt_arm`=1. Accepted beats are indexed from 0 after reset. Only beats whose index LSB equals `cfg_alt_odd` yield a word. That word is `sys_sa` unchanged, whatever `sys_bit2` or the lock state.
- R10: A one-cycle pulse on `clr_lost` or `clr_regained` clears the matching sticky flag on the next cycle. A new event on the same edge takes priority over the clear.
- R11: During reset, `out_valid`, `stat_locked`, `stat_lost` and `stat_regained` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_reg_en | input | 1 | Select configuration word (highest priority) |
| cfg_fdl_en | input | 1 | Select facility data-link stream |
| cfg_sys_en | input | 1 | Select system time-slot-0 stream |
| cfg_alt_mode | input | 1 | Alternate parity mode, first enable |
| cfg_alt_arm | input | 1 | Alternate parity mode, second enable |
| cfg_alt_odd | input | 1 | Parity taken in alternate mode (1 = odd beats) |
| cfg_sa | input | 5 | Configuration spare-bit word |
| fdl_valid | input | 1 | Facility word valid |
| fdl_ready | output | 1 | Facility word accepted |
| fdl_sa | input | 5 | Facility spare-bit word |
| sys_valid | input | 1 | System beat valid |
| sys_ready | output | 1 | System beat accepted |
| sys_bit2 | input | 1 | Bit 2 of the system frame's time slot 0 |
| sys_sa | input | 5 | Spare bits of the system frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_sa | output | 5 | Spare-bit word for the next transmitted frame |
| clr_lost | input | 1 | Clear pulse for `stat_lost` |
| clr_regained | input | 1 | Clear pulse for `stat_regained` |
| stat_locked | output | 1 | Biframe lock state |
| stat_lost | output | 1 | Sticky: biframe lock was lost |
| stat_regained | output | 1 | Sticky: biframe lock was gained |

## Verification
An output word appears on `out_sa` in the cycle after the edge that accepts its source beat or facility word. It leaves on the first edge where `out_ready` is high. The monitor therefore compares only at mid-cycle points where valid and ready are both high, and matches each word against the head of the expected queue. Lock and sticky status change on the edge of the beat that causes them. The bench reads them at the falling edge that follows, and for a clear it reads them one cycle after the pulse.

// File: rtl/sasel_pkg.sv
package sasel_pkg;
  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_FDL = 2'd1,
    SRC_SYS = 2'd2
  } src_e;
endpackage

// File: rtl/sasel_arb.sv
module sasel_arb
  import sasel_pkg::*;
(
  input  logic cfg_reg_en,
  input  logic cfg_fdl_en,
  input  logic cfg_sys_en,
  output src_e src
);
  // fixed priority: configuration word, facility link, system stream
  always_comb begin
    if (cfg_reg_en)      src = SRC_REG;
    else if (cfg_fdl_en) src = SRC_FDL;
    else if (cfg_sys_en) src = SRC_SYS;
    else                 src = SRC_REG;
  end
endmodule

// File: rtl/sasel_bfa_track.sv
module sasel_bfa_track #(
  parameter int LOCK_RUNS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic bit2,
  input  logic clr_lost,
  input  logic clr_regained,
  output logic locked_q,
  output logic locked_nxt,
  output logic lost_sticky,
  output logic regained_sticky,
  output logic parity_q
);
  localparam int RUN_W = $clog2(LOCK_RUNS + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUNS - 1);

  logic             prev_v, prev_b;
  logic [RUN_W-1:0] run_q, run_nxt;
  logic             alt_ok, ev_lose, ev_gain;

  assign alt_ok = prev_v && (bit2 != prev_b);

  always_comb begin
    locked_nxt = locked_q;
    run_nxt    = run_q;
    ev_lose    = 1'b0;
    ev_gain    = 1'b0;
    if (beat) begin
      if (locked_q) begin
        if (!alt_ok) begin
          locked_nxt = 1'b0;
          ev_lose    = 1'b1;
          run_nxt    = '0;
        end
      end else if (alt_ok) begin
        if (run_q == RUN_LAST) begin
          locked_nxt = 1'b1;
          ev_gain    = 1'b1;
          run_nxt    = '0;
        end else begin
          run_nxt = run_q + 1'b1;
        end
      end else begin
        run_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v          <= 1'b0;
      prev_b          <= 1'b0;
      run_q           <= '0;
      locked_q        <= 1'b0;
      lost_sticky     <= 1'b0;
      regained_sticky <= 1'b0;
      parity_q        <= 1'b0;
    end else begin
      run_q    <= run_nxt;
      locked_q <= locked_nxt;
      if (beat) begin
        prev_v   <= 1'b1;
        prev_b   <= bit2;
        parity_q <= ~parity_q;
      end
      if (ev_lose)        lost_sticky <= 1'b1;
      else if (clr_lost)  lost_sticky <= 1'b0;
      if (ev_gain)           regained_sticky <= 1'b1;
      else if (clr_regained) regained_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/sasel_out_stage.sv
module sasel_out_stage
  import sasel_pkg::*;
#(
  parameter int SA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  src_e            src,
  input  logic [SA_W-1:0] cfg_sa,
  input  logic            fdl_valid,
  input  logic [SA_W-1:0] fdl_sa,
  input  logic            sys_valid,
  input  logic            sys_bit2,
  input  logic [SA_W-1:0] sys_sa,
  input  logic            alt_on,
  input  logic            alt_odd,
  input  logic            sys_parity,
  input  logic            lock_nxt,
  input  logic            out_ready,
  output logic            fdl_ready,
  output logic            sys_ready,
  output logic            out_valid,
  output logic [SA_W-1:0] out_sa
);
  localparam logic [SA_W-1:0] FILL = '1;

  logic            slot_free, sys_take, load;
  logic [SA_W-1:0] load_d;

  assign slot_free = !out_valid || out_ready;
  assign fdl_ready = slot_free && (src == SRC_FDL);
  assign sys_ready = (src != SRC_SYS) || slot_free;
  assign sys_take  = alt_on ? (sys_parity == alt_odd) : sys_bit2;

  always_comb begin
    load   = 1'b0;
    load_d = cfg_sa;
    unique case (src)
      SRC_FDL: begin
        load   = fdl_valid && slot_free;
        load_d = fdl_sa;
      end
      SRC_SYS: begin
        load   = sys_valid && slot_free && sys_take;
        load_d = (!alt_on && !lock_nxt) ? FILL : sys_sa;
      end
      default: begin
        load   = slot_free;
        load_d = cfg_sa;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sa    <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_sa    <= load_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sa_source_sel.sv
module sa_source_sel
  import sasel_pkg::*;
#(
  parameter int SA_W      = 5,
  parameter int LOCK_RUNS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_reg_en,
  input  logic            cfg_fdl_en,
  input  logic            cfg_sys_en,
  input  logic            cfg_alt_mode,
  input  logic            cfg_alt_arm,
  input  logic            cfg_alt_odd,
  input  logic [SA_W-1:0] cfg_sa,
  input  logic            fdl_valid,
  output logic            fdl_ready,
  input  logic [SA_W-1:0] fdl_sa,
  input  logic            sys_valid,
  output logic            sys_ready,
  input  logic            sys_bit2,
  input  logic [SA_W-1:0] sys_sa,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [SA_W-1:0] out_sa,
  input  logic            clr_lost,
  input  logic            clr_regained,
  output logic            stat_locked,
  output logic            stat_lost,
  output logic            stat_regained
);
  src_e src;
  logic alt_on, beat, lock_nxt, parity;

  assign alt_on = cfg_alt_mode && cfg_alt_arm;
  assign beat   = sys_valid && sys_ready;

  sasel_arb u_arb (
    .cfg_reg_en (cfg_reg_en),
    .cfg_fdl_en (cfg_fdl_en),
    .cfg_sys_en (cfg_sys_en),
    .src        (src)
  );

  sasel_bfa_track #(.LOCK_RUNS(LOCK_RUNS)) u_trk (
    .clk             (clk),
    .rst_n           (rst_n),
    .beat            (beat),
    .bit2            (sys_bit2),
    .clr_lost        (clr_lost),
    .clr_regained    (clr_regained),
    .locked_q        (stat_locked),
    .locked_nxt      (lock_nxt),
    .lost_sticky     (stat_lost),
    .regained_sticky (stat_regained),
    .parity_q        (parity)
  );

  sasel_out_stage #(.SA_W(SA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (src),
    .cfg_sa     (cfg_sa),
    .fdl_valid  (fdl_valid),
    .fdl_sa     (fdl_sa),
    .sys_valid  (sys_valid),
    .sys_bit2   (sys_bit2),
    .sys_sa     (sys_sa),
    .alt_on     (alt_on),
    .alt_odd    (cfg_alt_odd),
    .sys_parity (parity),
    .lock_nxt   (lock_nxt),
    .out_ready  (out_ready),
    .fdl_ready  (fdl_ready),
    .sys_ready  (sys_ready),
    .out_valid  (out_valid),
    .out_sa     (out_sa)
  );
endmodule

// File: rtl/sasel_chk.sv
module sasel_chk #(
  parameter int SA_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_reg_en,
  input logic            fdl_ready,
  input logic            sys_valid,
  input logic            sys_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [SA_W-1:0] out_sa,
  input logic            clr_lost,
  input logic            clr_regained,
  input logic            stat_locked,
  input logic            stat_lost,
  input logic            stat_regained
);
  p_reg_blocks_fdl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reg_en |-> !fdl_ready);

  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sa)));

  p_no_accept_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !fdl_ready);

  p_gain_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_locked) |-> stat_regained);

  p_lock_needs_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_valid && sys_ready) |=> $stable(stat_locked));

  p_lost_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_locked) |-> stat_lost);

  p_clr_lost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lost && !stat_locked) |=> !stat_lost);

  p_clr_gain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_regained && stat_locked) |=> !stat_regained);
endmodule

bind sa_source_sel sasel_chk #(.SA_W(SA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_reg_en    (cfg_reg_en),
  .fdl_ready     (fdl_ready),
  .sys_valid     (sys_valid),
  .sys_ready     (sys_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_sa        (out_sa),
  .clr_lost      (clr_lost),
  .clr_regained  (clr_regained),
  .stat_locked   (stat_locked),
  .stat_lost     (stat_lost),
  .stat_regained (stat_regained)
);

// File: tb/sim_sa_source_sel.sv
`timescale 1ns/1ps
module sim_sa_source_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_reg_en = 0, cfg_fdl_en = 0, cfg_sys_en = 0;
  logic cfg_alt_mode = 0, cfg_alt_arm = 0, cfg_alt_odd = 0;
  logic [4:0] cfg_sa = 5'h15;
  logic fdl_valid = 0;
  logic [4:0] fdl_sa = '0;
  logic sys_valid = 0, sys_bit2 = 0;
  logic [4:0] sys_sa = '0;
  logic out_ready = 1'b1;
  logic clr_lost = 0, clr_regained = 0;
  logic fdl_ready, sys_ready, out_valid;
  logic [4:0] out_sa;
  logic stat_locked, stat_lost, stat_regained;

  int n_cmp = 0, n_bad = 0;
  bit reg_mode = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sa_source_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_reg_en(cfg_reg_en), .cfg_fdl_en(cfg_fdl_en), .cfg_sys_en(cfg_sys_en),
    .cfg_alt_mode(cfg_alt_mode), .cfg_alt_arm(cfg_alt_arm), .cfg_alt_odd(cfg_alt_odd),
    .cfg_sa(cfg_sa),
    .fdl_valid(fdl_valid), .fdl_ready(fdl_ready), .fdl_sa(fdl_sa),
    .sys_valid(sys_valid), .sys_ready(sys_ready), .sys_bit2(sys_bit2), .sys_sa(sys_sa),
    .out_valid(out_valid), .out_ready(out_ready), .out_sa(out_sa),
    .clr_lost(clr_lost), .clr_regained(clr_regained),
    .stat_locked(stat_locked), .stat_lost(stat_lost), .stat_regained(stat_regained)
  );

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare every output transfer against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (reg_mode) chk("R1 configuration word", out_sa, cfg_sa);
      else if (exp_q.size() > 0) chk(tag_q.pop_front(), out_sa, exp_q.pop_front());
      else begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected word actual=%h expected=none", out_sa);
      end
    end
  end

  task automatic push(logic [4:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic fdl_send(logic [4:0] v, string tag);
    @(posedge clk); #1;
    fdl_valid = 1'b1; fdl_sa = v;
    do @(negedge clk); while (!fdl_ready);
    push(v, tag);
    @(posedge clk); #1;
    fdl_valid = 1'b0;
  endtask

  task automatic sys_send(logic b2, logic [4:0] v, bit has_out, logic [4:0] e, string tag);
    @(posedge clk); #1;
    sys_valid = 1'b1; sys_bit2 = b2; sys_sa = v;
    do @(negedge clk); while (!sys_ready);
    if (has_out) push(e, tag);
    @(posedge clk); #1;
    sys_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk);
    chk("R11 out_valid in reset", {4'd0, out_valid}, 5'd0);
    chk("R11 stat_locked in reset", {4'd0, stat_locked}, 5'd0);
    chk("R11 stat_lost in reset", {4'd0, stat_lost}, 5'd0);
    chk("R11 stat_regained in reset", {4'd0, stat_regained}, 5'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 default source is the configuration word
    reg_mode = 1;
    repeat (4) @(negedge clk);
    chk("R1 default out_valid", {4'd0, out_valid}, 5'd1);
    // R1 priority over the other enables
    @(posedge clk); #1 cfg_reg_en = 1; cfg_fdl_en = 1; cfg_sys_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 fdl_ready low with register priority", {4'd0, fdl_ready}, 5'd0);

    // R2 facility link wins over the system stream
    @(posedge clk); #1 cfg_reg_en = 0;
    repeat (2) @(posedge clk);
    #1 reg_mode = 0;
    @(negedge clk);
    chk("R2 output idle after switch", {4'd0, out_valid}, 5'd0);
    fdl_send(5'h01, "R2 facility word 1");
    fdl_send(5'h1E, "R2 facility word 2");
    sys_send(1'b1, 5'h0F, 0, 5'h00, "R2 unused");
    repeat (3) @(negedge clk);
    chk("R2 system beat ignored", 5'(exp_q.size()), 5'd0);
    chk("R2 no stray word", {4'd0, out_valid}, 5'd0);

    // R4 back-pressure
    @(posedge clk); #1 out_ready = 0; fdl_valid = 1; fdl_sa = 5'h07;
    push(5'h07, "R4 held word");
    @(posedge clk); #1 fdl_sa = 5'h19;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 word held", out_sa, 5'h07);
      chk("R4 fdl_ready low while stalled", {4'd0, fdl_ready}, 5'd0);
    end
    @(posedge clk); #1 out_ready = 1;
    push(5'h19, "R4 second word after stall");
    @(negedge clk);
    chk("R4 fdl_ready after release", {4'd0, fdl_ready}, 5'd1);
    @(posedge clk); #1 fdl_valid = 0;
    repeat (3) @(negedge clk);
    chk("R4 queue drained", 5'(exp_q.size()), 5'd0);

    // R3 system stream, default mode
    cfg_fdl_en = 0; cfg_sys_en = 1;
    do_reset();
    sys_send(1'b1, 5'h03, 1, 5'h1F, "R8 unlocked word forced to ones");
    chk("R6 not locked after first beat", {4'd0, stat_locked}, 5'd0);
    sys_send(1'b0, 5'h0A, 0, 5'h00, "R5 unused");
    chk("R5 bit2=0 beat yields nothing", {4'd0, out_valid}, 5'd0);
    sys_send(1'b1, 5'h05, 1, 5'h05, "R3 locking beat word");
    chk("R6 locked after two alternations", {4'd0, stat_locked}, 5'd1);
    chk("R6 regained set", {4'd0, stat_regained}, 5'd1);
    chk("R7 lost still clear", {4'd0, stat_lost}, 5'd0);
    sys_send(1'b0, 5'h00, 0, 5'h00, "R5 unused");
    sys_send(1'b1, 5'h11, 1, 5'h11, "R8 locked word passes");
    sys_send(1'b1, 5'h0C, 1, 5'h1F, "R8 violating beat forced");
    chk("R7 unlocked after violation", {4'd0, stat_locked}, 5'd0);
    chk("R7 lost set", {4'd0, stat_lost}, 5'd1);

    // R10 clears
    @(posedge clk); #1 clr_regained = 1; clr_lost = 1;
    @(posedge clk); #1 clr_regained = 0; clr_lost = 0;
    @(negedge clk);
    chk("R10 regained cleared", {4'd0, stat_regained}, 5'd0);
    chk("R10 lost cleared", {4'd0, stat_lost}, 5'd0);
    sys_send(1'b0, 5'h00, 0, 5'h00, "R5 unused");
    sys_send(1'b1, 5'h06, 1, 5'h06, "R6 relock word");
    chk("R6 relocked", {4'd0, stat_locked}, 5'd1);
    chk("R6 regained set again", {4'd0, stat_regained}, 5'd1);
    repeat (3) @(negedge clk);
    chk("R3 all system words seen", 5'(exp_q.size()), 5'd0);

    // R9 alternate parity mode
    cfg_alt_mode = 1; cfg_alt_arm = 0; cfg_alt_odd = 1;
    do_reset();
    sys_send(1'b0, 5'h02, 0, 5'h00, "R9 unused");
    chk("R9 one enable is not enough", {4'd0, out_valid}, 5'd0);
    cfg_alt_arm = 1;
    sys_send(1'b0, 5'h0B, 1, 5'h0B, "R9 odd beat 1 taken");
    sys_send(1'b0, 5'h12, 0, 5'h00, "R9 unused");
    sys_send(1'b0, 5'h1D, 1, 5'h1D, "R9 odd beat 3 taken");
    repeat (3) @(negedge clk);
    chk("R9 even beats ignored", 5'(exp_q.size()), 5'd0);
    chk("R9 never locked", {4'd0, stat_locked}, 5'd0);

    finish_run();
  end
endmodule